// File: doc/BRIEF.md
# Atomic Memory Front End with Reservation Monitor

This block sits in front of a small on-chip word array and serves one request at a time. Each request names an operation, a byte address, a transfer size of 1, 2, 4 or 8 bytes, a requester context, write data and a compare value. The supported operations are plain read, plain write, reserving read, conditional store, swap and compare-and-swap. Each accepted request that expects an answer receives one response after a latency set by a configuration input. The response carries the read data, an error flag and the conditional-store outcome.

A reservation table inside the block holds one entry per context. A reserving read records the word it touched. Any store to a word drops every reservation on that word. A conditional store commits only while its own context still holds a reservation on the target word. A request can also be flagged as inhibited. Such a request is taken and then dropped without any trace.

Requests that leave the address window, are misaligned, use an unknown operation, or run a compare-and-swap at a narrow size are answered with the error flag set. They change nothing.

Top module: `amc_mem_ctrl`

## Requirements
- R1: A request is performed only when both its first byte address and its first byte address plus size lie inside the window. The window runs from BASE_ADDR up to BASE_ADDR + DEPTH*8. A request outside the window gets a response with rsp_err=1 and rsp_rdata=0, and it changes neither memory nor reservations.
- R2: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. An address that is not a multiple of the size is rejected with rsp_err=1 and has no effect.
- R3: A request taken with req_inhibit=1 produces no response. It changes no memory and no reservation, and req_ready stays high.
- R4: Command 0 (read) returns the addressed bytes zero-extended and right-aligned in rsp_rdata. Byte lane = addr[2:0], little-endian within the 64-bit word. Command 2 (reserving read) returns the same data and records a reservation on that word for req_ctx, replacing any earlier reservation of that context.
- R5: Command 1 (write) replaces only the bytes selected by size and address with the low bytes of req_wdata. rsp_rdata is 0.
- R6: Command 4 (swap) returns the old value at the location and writes req_wdata there.
- R7: Command 5 (compare-and-swap) always returns the old value. It writes req_wdata only when the old value equals the low bytes of req_cmp at the same size.
- R8: Compare-and-swap at sizes of 1 or 2 bytes is rejected with rsp_err=1 and no effect.
- R9: Command 3 (conditional store) writes and reports rsp_sc_ok=1 only if req_ctx holds a reservation on the target word. Otherwise it writes nothing and reports rsp_sc_ok=0. rsp_sc_ok is 0 for every other command.
- R10: Every committed store drops all reservations on that word, and so does every conditional-store attempt. A committed store is a write, a swap, a successful compare-and-swap or a successful conditional store.
- R11: A response appears as a one-cycle rsp_valid pulse exactly L cycles after the accepting edge. L is the value of cfg_latency at acceptance, with 0 treated as 1. req_ready is low from acceptance until the response cycle.
- R12: After reset, rsp_valid=0 and req_ready=1. With ZERO_INIT=1, every word reads back as 0.
- R13: Command codes 6 and 7 are answered with rsp_err=1 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_latency | input | LAT_W | Response latency in cycles, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_cmd | input | 3 | Operation code |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Size code |
| req_ctx | input | CTX_W | Requesting context |
| req_wdata | input | 64 | Store data, right-aligned |
| req_cmp | input | 64 | Compare value, right-aligned |
| req_inhibit | input | 1 | Drop request, no response |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Returned data, right-aligned |
| rsp_err | output | 1 | Request rejected |
| rsp_sc_ok | output | 1 | Conditional store succeeded |

## Verification
The memory and reservation updates happen on the accepting edge, but every result becomes visible only as the response, L edges after that edge. The bench drives a request in the falling half of a cycle and counts the edge that takes it as edge zero. It then looks on each later falling edge. On each earlier falling edge it requires rsp_valid to be low, and it compares data, error and store status on the falling edge after the L-th edge. For inhibited requests it watches several cycles for the absence of a response. Any effect on memory or reservations is then shown through later reads and conditional stores.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;

    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_RES_READ  = 3'd2,
        OP_COND_ST   = 3'd3,
        OP_SWAP      = 3'd4,
        OP_CMP_SWAP  = 3'd5
    } amc_op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

endpackage

// File: rtl/amc_addr_check.sv
`timescale 1ns/1ps
module amc_addr_check #(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   BASE_ADDR = 16'h0100,
    parameter int              DEPTH     = 16,
    parameter int              IDX_W     = 4
) (
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       size,
    input  logic [2:0]       cmd,
    output logic             fault,
    output logic [IDX_W-1:0] idx,
    output logic [2:0]       lane,
    output logic [7:0]       be
);
    import amc_pkg::*;

    localparam logic [AW:0] LO_X = {1'b0, BASE_ADDR};
    localparam logic [AW:0] HI_X = LO_X + (AW+1)'(DEPTH * 8);

    logic [AW:0] addr_x;
    logic [AW:0] span_x;
    logic [AW:0] end_x;
    logic [AW:0] off_x;
    logic [3:0]  nbytes;
    logic        in_window;
    logic        aligned;
    logic        cmd_known;
    logic        narrow_cas;

    always_comb begin
        addr_x    = {1'b0, addr};
        span_x    = '0;
        span_x[3:0] = 4'd1 << size;
        end_x     = addr_x + span_x;
        off_x     = addr_x - LO_X;
        nbytes    = 4'd1 << size;
        lane      = addr[2:0];
        idx       = off_x[IDX_W+2:3];
        in_window = (addr_x >= LO_X) && (end_x <= HI_X);
        unique case (size)
            2'd0:    aligned = 1'b1;
            2'd1:    aligned = (addr[0] == 1'b0);
            2'd2:    aligned = (addr[1:0] == 2'b00);
            default: aligned = (addr[2:0] == 3'b000);
        endcase
        cmd_known  = (cmd <= OP_LAST);
        narrow_cas = (cmd == OP_CMP_SWAP) && (size < 2'd2);
        fault      = !in_window || !aligned || !cmd_known || narrow_cas;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_be
        assign be[g] = (4'(g) >= {1'b0, lane}) && (4'(g) < ({1'b0, lane} + nbytes));
    end

endmodule

// File: rtl/amc_rmw_unit.sv
`timescale 1ns/1ps
module amc_rmw_unit (
    input  logic [63:0] old_word,
    input  logic [2:0]  lane,
    input  logic [1:0]  size,
    input  logic [7:0]  be,
    input  logic [63:0] wdata,
    input  logic [63:0] cmp,
    output logic [63:0] old_val,
    output logic [63:0] merged,
    output logic        cmp_eq
);
    import amc_pkg::*;

    logic [63:0] size_mask;
    logic [63:0] shifted;
    logic [5:0]  shamt;

    always_comb begin
        shamt = {lane, 3'b000};
        unique case (size)
            2'd0:    size_mask = 64'h0000_0000_0000_00FF;
            2'd1:    size_mask = 64'h0000_0000_0000_FFFF;
            2'd2:    size_mask = 64'h0000_0000_FFFF_FFFF;
            default: size_mask = '1;
        endcase
        old_val = (old_word >> shamt) & size_mask;
        shifted = wdata << shamt;
        cmp_eq  = (old_val == (cmp & size_mask));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*8 +: 8] = be[g] ? shifted[g*8 +: 8] : old_word[g*8 +: 8];
    end

endmodule

// File: rtl/amc_resv_monitor.sv
`timescale 1ns/1ps
module amc_resv_monitor #(
    parameter int NCTX  = 4,
    parameter int CTX_W = 2,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [CTX_W-1:0] set_ctx,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [CTX_W-1:0] chk_ctx,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_hit
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } resv_t;

    resv_t [NCTX-1:0] tab_d, tab_q;

    for (genvar g = 0; g < NCTX; g++) begin : g_entry
        always_comb begin
            tab_d[g] = tab_q[g];
            if (clr_en && tab_q[g].valid && (tab_q[g].idx == clr_idx)) begin
                tab_d[g].valid = 1'b0;
            end
            if (set_en && (set_ctx == CTX_W'(g))) begin
                tab_d[g].valid = 1'b1;
                tab_d[g].idx   = set_idx;
            end
        end
    end

    always_comb begin
        chk_hit = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            if ((chk_ctx == CTX_W'(i)) && tab_q[i].valid && (tab_q[i].idx == chk_idx)) begin
                chk_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/amc_mem_ctrl.sv
`timescale 1ns/1ps
module amc_mem_ctrl #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] BASE_ADDR = 16'h0100,
    parameter int            DEPTH     = 16,
    parameter int            NCTX      = 4,
    parameter int            LAT_W     = 4,
    parameter bit            ZERO_INIT = 1'b1,
    localparam int           CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] cfg_latency,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_cmd,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_size,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic [63:0]      req_wdata,
    input  logic [63:0]      req_cmp,
    input  logic             req_inhibit,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    output logic             rsp_err,
    output logic             rsp_sc_ok
);
    import amc_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic                    busy;
        logic [LAT_W-1:0]        cnt;
        logic                    rsp_valid;
        logic [63:0]             rdata;
        logic                    err;
        logic                    sc_ok;
        logic [DEPTH-1:0][63:0]  mem;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic             fault;
    logic [IDX_W-1:0] idx;
    logic [2:0]       lane;
    logic [7:0]       be;
    logic [63:0]      old_word;
    logic [63:0]      old_val;
    logic [63:0]      merged;
    logic             cmp_eq;
    logic             resv_hit;
    logic             set_en;
    logic             clr_en;
    logic             accept;
    logic             do_op;
    logic             commit;
    logic [LAT_W-1:0] lat_eff;

    amc_addr_check #(
        .AW        (AW),
        .BASE_ADDR (BASE_ADDR),
        .DEPTH     (DEPTH),
        .IDX_W     (IDX_W)
    ) u_addr_check (
        .addr  (req_addr),
        .size  (req_size),
        .cmd   (req_cmd),
        .fault (fault),
        .idx   (idx),
        .lane  (lane),
        .be    (be)
    );

    assign old_word = st_q.mem[idx];

    amc_rmw_unit u_rmw (
        .old_word (old_word),
        .lane     (lane),
        .size     (req_size),
        .be       (be),
        .wdata    (req_wdata),
        .cmp      (req_cmp),
        .old_val  (old_val),
        .merged   (merged),
        .cmp_eq   (cmp_eq)
    );

    amc_resv_monitor #(
        .NCTX  (NCTX),
        .CTX_W (CTX_W),
        .IDX_W (IDX_W)
    ) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_ctx (req_ctx),
        .set_idx (idx),
        .clr_en  (clr_en),
        .clr_idx (idx),
        .chk_ctx (req_ctx),
        .chk_idx (idx),
        .chk_hit (resv_hit)
    );

    always_comb begin
        st_d    = st_q;
        accept  = req_valid && !st_q.busy;
        do_op   = accept && !req_inhibit;
        lat_eff = (cfg_latency == '0) ? LAT_W'(1) : cfg_latency;
        set_en  = 1'b0;
        clr_en  = 1'b0;
        commit  = 1'b0;

        st_d.rsp_valid = 1'b0;

        if (st_q.busy) begin
            if (st_q.cnt <= LAT_W'(1)) begin
                st_d.busy      = 1'b0;
                st_d.rsp_valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - LAT_W'(1);
            end
        end

        if (do_op) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = lat_eff;
            st_d.rdata = '0;
            st_d.err   = fault;
            st_d.sc_ok = 1'b0;
            if (!fault) begin
                unique case (amc_op_e'(req_cmd))
                    OP_READ: begin
                        st_d.rdata = old_val;
                    end
                    OP_RES_READ: begin
                        st_d.rdata = old_val;
                        set_en     = 1'b1;
                    end
                    OP_WRITE: begin
                        commit = 1'b1;
                    end
                    OP_COND_ST: begin
                        clr_en     = 1'b1;
                        commit     = resv_hit;
                        st_d.sc_ok = resv_hit;
                    end
                    OP_SWAP: begin
                        st_d.rdata = old_val;
                        commit     = 1'b1;
                    end
                    OP_CMP_SWAP: begin
                        st_d.rdata = old_val;
                        commit     = cmp_eq;
                    end
                    default: begin
                        st_d.err = 1'b1;
                    end
                endcase
                if (commit) begin
                    clr_en          = 1'b1;
                    st_d.mem[idx]   = merged;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy      <= 1'b0;
            st_q.cnt       <= '0;
            st_q.rsp_valid <= 1'b0;
            st_q.rdata     <= '0;
            st_q.err       <= 1'b0;
            st_q.sc_ok     <= 1'b0;
            if (ZERO_INIT) begin
                st_q.mem <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rdata;
    assign rsp_err   = st_q.err;
    assign rsp_sc_ok = st_q.sc_ok;

endmodule

// File: rtl/amc_mem_ctrl_chk.sv
`timescale 1ns/1ps
module amc_mem_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_inhibit,
    input logic [2:0] req_cmd,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       rsp_sc_ok
);
    logic [2:0] last_cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd_q <= 3'd0;
        end else if (req_valid && req_ready && !req_inhibit) begin
            last_cmd_q <= req_cmd;
        end
    end

    // R11: a taken request blocks further requests in the next cycle
    assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_inhibit) |=> !req_ready);

    // R11: the response is a single-cycle pulse
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: the block is free again in the response cycle
    assert_ready_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R3: an inhibited request leaves no response and no busy period
    assert_inhibit_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_inhibit) |=> (!rsp_valid && req_ready));

    // R9: success status only for a conditional store that was not rejected
    assert_sc_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_sc_ok) |-> (!rsp_err && (last_cmd_q == 3'd3)));

endmodule

bind amc_mem_ctrl amc_mem_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_inhibit (req_inhibit),
    .req_cmd     (req_cmd),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_sc_ok   (rsp_sc_ok)
);

// File: tb/amc_mem_ctrl_bench.sv
`timescale 1ns/1ps
module amc_mem_ctrl_bench;

    localparam int            AW    = 16;
    localparam logic [15:0]   BASE  = 16'h0100;
    localparam int            DEPTH = 16;
    localparam int            NCTX  = 4;
    localparam int            LAT_W = 4;
    localparam int            TOP   = 16'h0100 + DEPTH * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LAT_W-1:0] cfg_latency = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_cmd = '0;
    logic [AW-1:0]    req_addr = '0;
    logic [1:0]       req_size = '0;
    logic [1:0]       req_ctx = '0;
    logic [63:0]      req_wdata = '0;
    logic [63:0]      req_cmp = '0;
    logic             req_inhibit = 1'b0;
    logic             rsp_valid;
    logic [63:0]      rsp_rdata;
    logic             rsp_err;
    logic             rsp_sc_ok;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [63:0] m_mem [DEPTH];
    bit          m_rv  [NCTX];
    int          m_rw  [NCTX];

    always #10 clk = ~clk;

    amc_mem_ctrl #(
        .AW        (AW),
        .BASE_ADDR (BASE),
        .DEPTH     (DEPTH),
        .NCTX      (NCTX),
        .LAT_W     (LAT_W),
        .ZERO_INIT (1'b1)
    ) u_amc_mem_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_latency (cfg_latency),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_cmd     (req_cmd),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_ctx     (req_ctx),
        .req_wdata   (req_wdata),
        .req_cmp     (req_cmp),
        .req_inhibit (req_inhibit),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .rsp_sc_ok   (rsp_sc_ok)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0: return 64'hFF;
            2'd1: return 64'hFFFF;
            2'd2: return 64'hFFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic string req_tag(input logic [2:0] cmd);
        case (cmd)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R4";
            3'd3: return "R9";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R13";
        endcase
    endfunction

    // Expected behaviour from the requirements; updates the model state.
    task automatic model(input logic [2:0] cmd, input logic [15:0] addr,
                         input logic [1:0] sz, input int ctx,
                         input logic [63:0] wd, input logic [63:0] cp,
                         output logic [63:0] rd, output bit err, output bit ok);
        int nb, off, w, last;
        bit store;
        logic [63:0] msk, oldv, nw;
        nb   = 1 << sz;
        msk  = size_mask(sz);
        err  = 1'b0;
        ok   = 1'b0;
        rd   = '0;
        last = int'(addr) + nb;
        if (int'(addr) < int'(BASE) || last > TOP) err = 1'b1;
        if ((int'(addr) % nb) != 0) err = 1'b1;
        if (cmd > 3'd5) err = 1'b1;
        if (cmd == 3'd5 && sz < 2) err = 1'b1;
        if (err) return;
        w    = (int'(addr) - int'(BASE)) / 8;
        off  = int'(addr) % 8;
        oldv = (m_mem[w] >> (off * 8)) & msk;
        nw   = m_mem[w];
        for (int b = 0; b < 8; b++) begin
            if (b >= off && b < off + nb) nw[b*8 +: 8] = wd[(b-off)*8 +: 8];
        end
        store = 1'b0;
        case (cmd)
            3'd0: rd = oldv;
            3'd2: begin rd = oldv; m_rv[ctx] = 1'b1; m_rw[ctx] = w; end
            3'd1: store = 1'b1;
            3'd3: begin
                ok    = m_rv[ctx] && (m_rw[ctx] == w);
                store = ok;
                for (int c = 0; c < NCTX; c++) if (m_rv[c] && m_rw[c] == w) m_rv[c] = 1'b0;
            end
            3'd4: begin rd = oldv; store = 1'b1; end
            default: begin rd = oldv; store = (oldv == (cp & msk)); end
        endcase
        if (store) begin
            m_mem[w] = nw;
            for (int c = 0; c < NCTX; c++) if (m_rv[c] && m_rw[c] == w) m_rv[c] = 1'b0;
        end
    endtask

    task automatic txn(input logic [2:0] cmd, input logic [15:0] addr,
                       input logic [1:0] sz, input int ctx,
                       input logic [63:0] wd, input logic [63:0] cp,
                       input bit inh, input int lat, input string tag);
        logic [63:0] e_rd;
        bit e_err, e_ok;
        int eff;
        bit early;
        e_rd = '0; e_err = 1'b0; e_ok = 1'b0;
        if (!inh) model(cmd, addr, sz, ctx, wd, cp, e_rd, e_err, e_ok);
        @(negedge clk);
        cfg_latency = LAT_W'(lat);
        req_cmd     = cmd;
        req_addr    = addr;
        req_size    = sz;
        req_ctx     = 2'(ctx);
        req_wdata   = wd;
        req_cmp     = cp;
        req_inhibit = inh;
        req_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid   = 1'b0;
        req_inhibit = 1'b0;
        if (inh) begin
            early = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (rsp_valid !== 1'b0 || req_ready !== 1'b1) early = 1'b1;
                @(negedge clk);
            end
            check("R3", {tag, " no response, ready high"}, 64'(early), 64'd0);
            return;
        end
        check("R11", {tag, " ready low after take"}, 64'(req_ready), 64'd0);
        eff   = (lat == 0) ? 1 : lat;
        early = 1'b0;
        for (int i = 1; i <= eff; i++) begin
            @(negedge clk);
            if (i < eff && rsp_valid !== 1'b0) early = 1'b1;
        end
        check("R11", {tag, " no early response"}, 64'(early), 64'd0);
        check("R11", {tag, " rsp_valid at latency"}, 64'(rsp_valid), 64'd1);
        check(e_err ? ((cmd > 3'd5) ? "R13" : (cmd == 3'd5 && sz < 2) ? "R8" : "R1/R2")
                    : req_tag(cmd), {tag, " rsp_err"}, 64'(rsp_err), 64'(e_err));
        check(req_tag(cmd), {tag, " rsp_rdata"}, rsp_rdata, e_rd);
        check("R9", {tag, " rsp_sc_ok"}, 64'(rsp_sc_ok), 64'(e_ok));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [1:0]  s;
        logic [2:0]  c;
        int          sel;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        for (int i = 0; i < NCTX; i++) begin m_rv[i] = 1'b0; m_rw[i] = 0; end
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "ready after reset", 64'(req_ready), 64'd1);
        check("R12", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        // R12 zero init at first and last word
        txn(3'd0, BASE, 2'd3, 0, '0, '0, 1'b0, 1, "R12 first word");
        txn(3'd0, 16'(TOP - 8), 2'd3, 0, '0, '0, 1'b0, 3, "R12 last word");

        // R5 byte lanes, R4 sub-word reads
        txn(3'd1, BASE, 2'd3, 0, 64'h1122_3344_5566_7788, '0, 1'b0, 2, "R5 full word");
        txn(3'd1, BASE + 16'd2, 2'd1, 1, 64'hFFFF_FFFF_FFFF_ABCD, '0, 1'b0, 1, "R5 halfword lane 2");
        txn(3'd0, BASE + 16'd3, 2'd0, 0, '0, '0, 1'b0, 0, "R4 byte lane 3");
        txn(3'd0, BASE + 16'd4, 2'd2, 0, '0, '0, 1'b0, 5, "R4 upper word");
        txn(3'd0, BASE, 2'd3, 0, '0, '0, 1'b0, 7, "R4 whole word");

        // R1 window edges, R2 alignment
        txn(3'd0, BASE - 16'd1, 2'd0, 0, '0, '0, 1'b0, 1, "R1 below base");
        txn(3'd1, 16'(TOP), 2'd0, 0, 64'hAA, '0, 1'b0, 1, "R1 at limit");
        txn(3'd0, 16'(TOP - 1), 2'd0, 0, '0, '0, 1'b0, 1, "R1 last byte");
        txn(3'd1, BASE + 16'd1, 2'd1, 0, 64'h55, '0, 1'b0, 2, "R2 odd halfword");
        txn(3'd4, BASE + 16'd4, 2'd3, 0, 64'h55, '0, 1'b0, 2, "R2 misaligned swap");

        // R6 swap
        txn(3'd4, BASE + 16'd8, 2'd3, 2, 64'hDEAD_BEEF_0000_0001, '0, 1'b0, 2, "R6 swap");
        txn(3'd4, BASE + 16'd8, 2'd3, 2, 64'h0, '0, 1'b0, 2, "R6 swap back");

        // R7 compare-and-swap, R8 size rule
        txn(3'd5, BASE + 16'd16, 2'd2, 0, 64'h77, 64'h0, 1'b0, 1, "R7 cas equal 4B");
        txn(3'd5, BASE + 16'd16, 2'd2, 0, 64'h99, 64'h1, 1'b0, 1, "R7 cas unequal 4B");
        txn(3'd5, BASE + 16'd24, 2'd3, 0, 64'h1234, 64'h0, 1'b0, 1, "R7 cas equal 8B");
        txn(3'd5, BASE + 16'd24, 2'd1, 0, 64'h1, 64'h1234, 1'b0, 1, "R8 cas 2B");
        txn(3'd5, BASE + 16'd24, 2'd0, 0, 64'h1, 64'h34, 1'b0, 1, "R8 cas 1B");
        txn(3'd0, BASE + 16'd24, 2'd3, 0, '0, '0, 1'b0, 1, "R8 unchanged");

        // R13 unknown operations
        txn(3'd6, BASE, 2'd3, 0, 64'h1, '0, 1'b0, 1, "R13 code 6");
        txn(3'd7, BASE, 2'd3, 0, 64'h1, '0, 1'b0, 1, "R13 code 7");
        txn(3'd0, BASE, 2'd3, 0, '0, '0, 1'b0, 1, "R13 unchanged");

        // R9 conditional store
        txn(3'd2, BASE + 16'd32, 2'd3, 1, '0, '0, 1'b0, 1, "R4 reserve ctx1");
        txn(3'd3, BASE + 16'd32, 2'd3, 1, 64'hC0FFEE, '0, 1'b0, 1, "R9 sc own reservation");
        txn(3'd3, BASE + 16'd32, 2'd3, 1, 64'hBAD, '0, 1'b0, 1, "R9 sc after consume");
        txn(3'd2, BASE + 16'd40, 2'd3, 0, '0, '0, 1'b0, 1, "R9 reserve ctx0");
        txn(3'd3, BASE + 16'd40, 2'd3, 3, 64'h1, '0, 1'b0, 1, "R9 sc other ctx");
        txn(3'd3, BASE + 16'd40, 2'd3, 0, 64'h2, '0, 1'b0, 1, "R10 sc after foreign attempt");

        // R10 clearing by plain store and swap
        txn(3'd2, BASE + 16'd48, 2'd3, 0, '0, '0, 1'b0, 1, "R10 reserve ctx0");
        txn(3'd2, BASE + 16'd48, 2'd3, 2, '0, '0, 1'b0, 1, "R10 reserve ctx2");
        txn(3'd1, BASE + 16'd52, 2'd0, 3, 64'h5A, '0, 1'b0, 1, "R10 byte store");
        txn(3'd3, BASE + 16'd48, 2'd3, 0, 64'h3, '0, 1'b0, 1, "R10 sc ctx0 cleared");
        txn(3'd3, BASE + 16'd48, 2'd3, 2, 64'h4, '0, 1'b0, 1, "R10 sc ctx2 cleared");
        txn(3'd2, BASE + 16'd56, 2'd3, 1, '0, '0, 1'b0, 1, "R10 reserve ctx1");
        txn(3'd4, BASE + 16'd56, 2'd3, 2, 64'h9, '0, 1'b0, 1, "R10 swap");
        txn(3'd3, BASE + 16'd56, 2'd3, 1, 64'h8, '0, 1'b0, 1, "R10 sc after swap");

        // R3 inhibit has no effect
        txn(3'd1, BASE, 2'd3, 0, 64'hFFFF, '0, 1'b1, 2, "R3 inhibited write");
        txn(3'd0, BASE, 2'd3, 0, '0, '0, 1'b0, 1, "R3 memory kept");
        txn(3'd2, BASE + 16'd64, 2'd3, 3, '0, '0, 1'b1, 1, "R3 inhibited reserve");
        txn(3'd3, BASE + 16'd64, 2'd3, 3, 64'h1, '0, 1'b0, 1, "R3 no reservation made");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            c   = 3'($urandom_range(0, 7));
            if (c > 3'd5 && $urandom_range(0, 3) != 0) c = 3'($urandom_range(0, 5));
            s   = 2'($urandom_range(0, 3));
            sel = $urandom_range(0, 9);
            if (sel < 8) begin
                a = BASE + 16'($urandom_range(0, 3) * 8) + 16'($urandom_range(0, 7));
                a = a & ~16'((1 << s) - 1);
            end else if (sel == 8) begin
                a = BASE + 16'($urandom_range(0, DEPTH * 8 - 1));
            end else begin
                a = 16'($urandom_range(16'h00F0, 16'h0190));
            end
            txn(c, a, s, $urandom_range(0, NCTX - 1),
                {$urandom, $urandom},
                ($urandom_range(0, 1) != 0) ? (m_mem[3 & ((int'(a) - int'(BASE)) / 8)] >> (8 * (a % 8))) : 64'($urandom),
                ($urandom_range(0, 15) == 0), $urandom_range(0, 4),
                $sformatf("random %0d %s", n, req_tag(c)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule